// File: doc/BRIEF.md
# Register Redirection Table

This block translates the register number encoded in an instruction into the physical register that is actually accessed. It holds a small table of programmable entries. Each entry names a key register, the register-file type it applies to (integer or floating-point), and the target index that replaces the key. Two lookup ports each take a register number and a type flag. They return the redirected index in the same cycle, so both source operands of an instruction can be translated together. A register number with no matching entry comes back unchanged.

Software programs the table one slot at a time through a write port. A write either loads a slot or invalidates it. Integer register 2 is the stack pointer and must never be renamed. The write port therefore refuses any entry that would send integer register 2 anywhere other than index 2. A refused write leaves the table untouched and raises an error pulse.

Top module: `regredir_table`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every slot, so afterwards each lookup returns its input register number with its hit output low.
- R2: A write with `wr_en` high and `wr_valid` high that is accepted loads the slot addressed by `wr_slot` at the next clock edge. From then on, a lookup with the same key and type returns the stored target with its hit output high.
- R3: A slot matches a lookup only when its key equals the looked-up register number and its type flag equals the lookup's type flag (0 = integer, 1 = floating-point).
- R4: A lookup that no valid slot matches returns its input register number unchanged, with its hit output low.
- R5: When several valid slots match one lookup, the slot with the lowest slot number supplies the target.
- R6: A write with `wr_valid` high, type 0, key 2 and a target other than 2 is rejected. No slot changes, and `wr_err` is high for exactly the one cycle that follows that clock edge. Every other write leaves `wr_err` low.
- R7: A lookup of integer register 2 always returns index 2.
- R8: A write with `wr_valid` low invalidates the addressed slot, so that slot no longer takes part in lookups.
- R9: The two lookup ports are independent and each translates its own input in the same cycle.
- R10: Floating-point register 2 has no restriction and may be redirected to any index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one slot |
| wr_slot | input | 4 | Slot number to write |
| wr_valid | input | 1 | 1 loads the slot, 0 invalidates it |
| wr_fp | input | 1 | Type of the entry: 0 integer, 1 floating-point |
| wr_key | input | 5 | Register number to match |
| wr_tgt | input | 5 | Replacement register index |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| lk_reg_a | input | 5 | Register number for port A |
| lk_fp_a | input | 1 | Type for port A |
| lk_idx_a | output | 5 | Translated index for port A |
| lk_hit_a | output | 1 | Port A matched a valid slot |
| lk_reg_b | input | 5 | Register number for port B |
| lk_fp_b | input | 1 | Type for port B |
| lk_idx_b | output | 5 | Translated index for port B |
| lk_hit_b | output | 1 | Port B matched a valid slot |

## Verification
The lookups are combinational, so a corrupted slot shows on either port in the same cycle that a matching register number is presented. The bench looks up after every write, so a bad store shows within one cycle. A stale valid bit or a wrong winner among duplicate keys gives a wrong index or a wrong hit flag at once. A rejected write that still changes the table shows on the next lookup of the overwritten key. An error pulse that is missing or lasts too long shows at the ports one cycle after the offending edge.

// File: rtl/regredir_pkg.sv
package regredir_pkg;
  localparam int REG_W  = 5;
  localparam int SP_REG = 2;

  typedef struct packed {
    logic             valid;
    logic             fp;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] tgt;
  } redir_entry_t;

  // True when an entry would rename the integer stack pointer
  function automatic logic sp_violation(input logic v, input logic f,
                                        input logic [REG_W-1:0] k,
                                        input logic [REG_W-1:0] t);
    return v && !f && (k == REG_W'(SP_REG)) && (t != REG_W'(SP_REG));
  endfunction
endpackage

// File: rtl/regredir_bank.sv
module regredir_bank
  import regredir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int SLOT_W = $clog2(NUM_ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [SLOT_W-1:0]               wr_slot,
  input  logic                            wr_valid,
  input  logic                            wr_fp,
  input  logic [REG_W-1:0]                wr_key,
  input  logic [REG_W-1:0]                wr_tgt,
  output redir_entry_t [NUM_ENTRIES-1:0]  ent_q,
  output logic                            wr_err
);
  logic wr_reject;
  logic wr_accept;

  assign wr_reject = wr_en && sp_violation(wr_valid, wr_fp, wr_key, wr_tgt);
  assign wr_accept = wr_en && !wr_reject;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q <= '0;
    end else if (wr_accept) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (wr_slot == SLOT_W'(i)) begin
          ent_q[i].valid <= wr_valid;
          ent_q[i].fp    <= wr_fp;
          ent_q[i].key   <= wr_key;
          ent_q[i].tgt   <= wr_tgt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_reject;
  end

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> (ent_q == $past(ent_q))); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> (ent_q[$past(wr_slot)].valid == $past(wr_valid))); // R2

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_sp_chk
      AST_SP_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        !sp_violation(ent_q[g].valid, ent_q[g].fp, ent_q[g].key, ent_q[g].tgt)); // R6
    end
  endgenerate
endmodule

// File: rtl/regredir_lookup.sv
module regredir_lookup
  import regredir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  redir_entry_t [NUM_ENTRIES-1:0]  ent,
  input  logic [REG_W-1:0]                q_reg,
  input  logic                            q_fp,
  output logic [REG_W-1:0]                q_idx,
  output logic                            q_hit
);
  logic [NUM_ENTRIES-1:0] match_vec;
  logic [NUM_ENTRIES-1:0] win_vec;
  logic [REG_W-1:0]       sel_tgt;

  // Isolate the lowest set bit: lowest slot number wins
  function automatic logic [NUM_ENTRIES-1:0] lowest_one(input logic [NUM_ENTRIES-1:0] v);
    return v & (~v + NUM_ENTRIES'(1));
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      match_vec[i] = ent[i].valid && (ent[i].fp == q_fp) && (ent[i].key == q_reg);
    end
  end

  assign win_vec = lowest_one(match_vec);

  always_comb begin
    sel_tgt = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      sel_tgt = sel_tgt | ({REG_W{win_vec[i]}} & ent[i].tgt);
    end
  end

  assign q_hit = |match_vec;
  assign q_idx = q_hit ? sel_tgt : q_reg;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_vec)); // R5

  AST_SP_SELF: assert property (@(posedge clk) disable iff (rst)
    (!q_fp && q_reg == REG_W'(SP_REG)) |-> (q_idx == REG_W'(SP_REG))); // R7

  AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    !q_hit |-> (q_idx == q_reg)); // R4
endmodule

// File: rtl/regredir_table.sv
module regredir_table
  import regredir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int SLOT_W = $clog2(NUM_ENTRIES),
  localparam int NUM_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic              wr_fp,
  input  logic [REG_W-1:0]  wr_key,
  input  logic [REG_W-1:0]  wr_tgt,
  output logic              wr_err,
  input  logic [REG_W-1:0]  lk_reg_a,
  input  logic              lk_fp_a,
  output logic [REG_W-1:0]  lk_idx_a,
  output logic              lk_hit_a,
  input  logic [REG_W-1:0]  lk_reg_b,
  input  logic              lk_fp_b,
  output logic [REG_W-1:0]  lk_idx_b,
  output logic              lk_hit_b
);
  redir_entry_t [NUM_ENTRIES-1:0] ent_q;
  logic [NUM_PORTS-1:0][REG_W-1:0] p_reg;
  logic [NUM_PORTS-1:0]            p_fp;
  logic [NUM_PORTS-1:0][REG_W-1:0] p_idx;
  logic [NUM_PORTS-1:0]            p_hit;

  regredir_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_valid(wr_valid), .wr_fp(wr_fp), .wr_key(wr_key), .wr_tgt(wr_tgt),
    .ent_q(ent_q), .wr_err(wr_err)
  );

  assign p_reg = {lk_reg_b, lk_reg_a};
  assign p_fp  = {lk_fp_b, lk_fp_a};

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      regredir_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
        .clk(clk), .rst(rst), .ent(ent_q),
        .q_reg(p_reg[p]), .q_fp(p_fp[p]),
        .q_idx(p_idx[p]), .q_hit(p_hit[p])
      );
    end
  endgenerate

  assign lk_idx_a = p_idx[0];
  assign lk_hit_a = p_hit[0];
  assign lk_idx_b = p_idx[1];
  assign lk_hit_b = p_hit[1];

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (wr_err && !wr_en) |=> !wr_err); // R6
endmodule

// File: tb/regredir_table_tb.sv
module regredir_table_tb;
  localparam int N = 16;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, wr_valid = 0, wr_fp = 0;
  logic [3:0] wr_slot = 0;
  logic [4:0] wr_key = 0, wr_tgt = 0;
  logic wr_err;
  logic [4:0] lk_reg_a = 0, lk_reg_b = 0;
  logic lk_fp_a = 0, lk_fp_b = 0;
  logic [4:0] lk_idx_a, lk_idx_b;
  logic lk_hit_a, lk_hit_b;

  int n_cmp = 0, n_bad = 0;
  bit m_valid [N];
  bit m_fp [N];
  int m_key [N];
  int m_tgt [N];

  always #5 clk = ~clk;

  regredir_table u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_valid(wr_valid),
    .wr_fp(wr_fp), .wr_key(wr_key), .wr_tgt(wr_tgt), .wr_err(wr_err),
    .lk_reg_a(lk_reg_a), .lk_fp_a(lk_fp_a), .lk_idx_a(lk_idx_a), .lk_hit_a(lk_hit_a),
    .lk_reg_b(lk_reg_b), .lk_fp_b(lk_fp_b), .lk_idx_b(lk_idx_b), .lk_hit_b(lk_hit_b)
  );

  function automatic int exp_idx(int r, bit f);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_fp[i] == f && m_key[i] == r) return m_tgt[i];
    return r;
  endfunction

  function automatic bit exp_hit(int r, bit f);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_fp[i] == f && m_key[i] == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit is_bad(bit v, bit f, int k, int t);
    return v && !f && k == 2 && t != 2;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(int slot, bit v, bit f, int k, int t, string tag);
    bit bad;
    @(negedge clk);
    wr_en = 1; wr_slot = 4'(slot); wr_valid = v; wr_fp = f; wr_key = 5'(k); wr_tgt = 5'(t);
    @(negedge clk);
    wr_en = 0;
    bad = is_bad(v, f, k, t);
    cmp({tag, " wr_err"}, int'(wr_err), int'(bad));
    if (!bad) begin
      m_valid[slot] = v; m_fp[slot] = f; m_key[slot] = k; m_tgt[slot] = t;
    end
  endtask

  task automatic lookup(int ra, bit fa, int rb, bit fb, string tag);
    lk_reg_a = 5'(ra); lk_fp_a = fa; lk_reg_b = 5'(rb); lk_fp_b = fb;
    #1;
    cmp({tag, " idx_a"}, int'(lk_idx_a), exp_idx(ra, fa));
    cmp({tag, " hit_a"}, int'(lk_hit_a), int'(exp_hit(ra, fa)));
    cmp({tag, " idx_b"}, int'(lk_idx_b), exp_idx(rb, fb));
    cmp({tag, " hit_b"}, int'(lk_hit_b), int'(exp_hit(rb, fb)));
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_fp[i] = 0; m_key[i] = 0; m_tgt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: empty after reset
    cmp("R1 wr_err", int'(wr_err), 0);
    lookup(5, 0, 2, 0, "R1");
    lookup(31, 1, 0, 1, "R1");
    // R2 / R3
    do_write(3, 1, 0, 5, 20, "R2");
    lookup(5, 0, 5, 1, "R2 R3");
    // R10: fp x2 free to move
    do_write(4, 1, 1, 2, 9, "R10");
    lookup(2, 1, 2, 0, "R10 R7");
    // R6: illegal integer x2 writes
    do_write(5, 1, 0, 2, 7, "R6");
    @(negedge clk);
    cmp("R6 err one cycle", int'(wr_err), 0);
    lookup(2, 0, 5, 0, "R6 R7");
    do_write(3, 1, 0, 2, 9, "R6 overwrite");
    lookup(5, 0, 2, 0, "R6 unchanged");
    do_write(6, 1, 0, 2, 2, "R7 legal sp");
    lookup(2, 0, 3, 0, "R7 R4");
    // R5 priority, R8 invalidation
    do_write(8, 1, 0, 11, 30, "R5");
    do_write(7, 1, 0, 11, 1, "R5");
    lookup(11, 0, 5, 0, "R5 R9");
    do_write(7, 0, 0, 11, 1, "R8");
    lookup(11, 0, 11, 1, "R8");
    // Random mix: R2 R3 R4 R5 R6 R9
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 9) < 6) begin
        int k, t;
        k = $urandom_range(0, 7);
        t = $urandom_range(0, 31);
        if (k == 2 && $urandom_range(0, 1) == 1) t = 2;
        do_write($urandom_range(0, N - 1), $urandom_range(0, 9) < 8,
                 $urandom_range(0, 1) == 1, k, t, "RND R6");
      end
      @(negedge clk);
      lookup($urandom_range(0, 9), $urandom_range(0, 1) == 1,
             $urandom_range(0, 9), $urandom_range(0, 1) == 1, "RND R5 R9");
    end
    // R1 again: reset clears a populated table
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    lookup(11, 0, 5, 0, "R1 rereset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule